// File: doc/BRIEF.md
# UART Transmit Path with Holding Queue

This block turns bytes written by a host into an asynchronous serial stream. Each write on the holding-register port lands in a queue. When queue mode is on, the queue holds up to 64 bytes. When it is off, the queue behaves as a single holding register. A shift register takes the oldest byte and sends the character. The character is a low start bit, 5 to 8 data bits sent least-significant first, an optional odd or even parity bit, and a high stop period of one, one and a half or two bit times. Timing comes from a sample tick supplied by an external baud generator. One bit time is 16 ticks.

The block keeps two status flags. The holding-empty flag says that no byte is waiting in the queue. The shifter-idle flag says that no character is on the wire. When the holding-empty condition arises while the interrupt enable is set, a transmit-empty interrupt becomes pending. Reading the interrupt identification acknowledges it, and it stays cleared until the next empty event. When bytes are waiting, characters go out back to back with no idle gap.

Top module: `uart_tx_core`

## Requirements
- R1: After reset `txd` is 1, `thr_empty` is 1, `tsr_empty` is 1 and `irq` is 0.
- R2: A character is a 0 start bit followed by the data bits, sent LSB first. The number of data bits comes from `word_len`: 00=5, 01=6, 10=7, 11=8. Unused upper bits of the byte are not sent.
- R3: When `par_en` is 1, a parity bit follows the last data bit. With `par_even`=1 it makes the count of ones over data plus parity even. With `par_even`=0 it makes that count odd. When `par_en` is 0, no parity bit is sent.
- R4: The stop period is high. It lasts 1 bit when `stop_two`=0, and 2 bits when `stop_two`=1. With 5 data bits and `stop_two`=1 it lasts 1.5 bits.
- R5: Every bit lasts 16 cycles in which `tick` is 1. A cycle with `tick`=0 holds the frame where it is, with `txd` stable. A frame therefore lasts 16*(1+n+p) ticks plus 16, 24 or 32 stop ticks.
- R6: With `fifo_en`=1, up to 64 bytes wait in the queue, in addition to the byte in the shift register. They leave in write order. A write to a full queue is dropped.
- R7: With `fifo_en`=0, a single holding register is used. A second write while it still holds a byte is dropped.
- R8: After an accepted write, `thr_empty` reads 0 from the next cycle. When the last queued byte moves into an idle shift register, which happens one cycle after the write, `thr_empty` returns to 1. `thr_empty` never rises without a byte leaving the queue.
- R9: `tsr_empty` falls in the cycle the start bit begins. It stays 0 for the whole frame and rises only after the last stop tick when nothing is queued.
- R10: When a byte is queued, the next start bit begins directly after the last stop tick. Start-to-start spacing equals the frame length.
- R11: A transmit-empty interrupt becomes pending when `thr_empty` and `thr_ie` become true together. `irq` is high while it is pending and `thr_ie` and `thr_empty` are 1. With `thr_ie`=0, `irq` stays 0.
- R12: A one-cycle pulse on `iid_rd` clears the pending interrupt. It stays clear until the next empty event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample tick from the baud generator (16 per bit) |
| fifo_en | input | 1 | 1: 64-byte queue, 0: single holding register |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| word_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| par_en | input | 1 | Insert a parity bit |
| par_even | input | 1 | 1: even parity, 0: odd parity |
| stop_two | input | 1 | 1: two stop bits (1.5 with 5 data bits) |
| thr_ie | input | 1 | Transmit-empty interrupt enable |
| iid_rd | input | 1 | Interrupt identification read, acknowledges the interrupt |
| txd | output | 1 | Serial output, idles high |
| thr_empty | output | 1 | Holding register / queue empty |
| tsr_empty | output | 1 | Shift register idle, no frame in progress |
| irq | output | 1 | Transmit-empty interrupt |

## Verification
A write at a clock edge shows as `thr_empty`=0 at the next sample. One edge later the byte moves into the shift register, so `thr_empty` returns to 1 and `tsr_empty` and `txd` fall. The interrupt follows the empty event by one more edge. The bench drives every input on the falling edge and samples on the falling edge at exactly those counts. It measures a frame as the number of falling-edge samples with `tsr_empty` low, and measures back-to-back spacing from start to start. A monitor decodes each character by sampling 8 cycles into the start bit and then every 16 cycles, so each bit is read at its centre.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] wlen;      // 0..3 -> 5..8 data bits
        logic       par_en;
        logic       par_even;
        logic       stop_two;
    } frame_cfg_t;

    function automatic logic [3:0] data_bits(input logic [1:0] wlen);
        return 4'd5 + {2'b00, wlen};
    endfunction

    function automatic logic [7:0] width_mask(input logic [1:0] wlen);
        return 8'hFF >> (2'd3 - wlen);
    endfunction

    function automatic logic parity_bit(input logic [7:0] data, input frame_cfg_t cfg);
        logic x;
        x = ^(data & width_mask(cfg.wlen));
        return cfg.par_even ? x : ~x;
    endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_mode,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count, cap;
    logic             do_push, do_pop;

    function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign cap     = fifo_mode ? CW'(DEPTH) : CW'(1);
    assign full    = (count >= cap);
    assign empty   = (count == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // R6: occupancy never exceeds the storage
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R6/R7: a write into a full queue leaves occupancy untouched
    a_r7_full_drop: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)));

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic       have_data,
    input  logic [7:0] next_byte,
    output logic       take,
    output logic       txd,
    output logic       idle
);
    localparam int TW = $clog2(2 * TICKS_PER_BIT);
    localparam logic [TW-1:0] LAST_1  = TW'(TICKS_PER_BIT - 1);
    localparam logic [TW-1:0] LAST_15 = TW'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
    localparam logic [TW-1:0] LAST_2  = TW'(2 * TICKS_PER_BIT - 1);

    tx_state_e  state;
    logic [7:0] shreg;
    frame_cfg_t cfg_q;
    logic       par_q;
    logic [TW-1:0] tcnt, last_tick;
    logic [2:0] bcnt;
    logic       bit_done, last_data;

    always_comb begin
        last_tick = LAST_1;
        if (state == ST_STOP && cfg_q.stop_two)
            last_tick = (cfg_q.wlen == 2'd0) ? LAST_15 : LAST_2;
    end

    assign bit_done  = tick && (state != ST_IDLE) && (tcnt == last_tick);
    assign last_data = (bcnt == 3'(data_bits(cfg_q.wlen) - 4'd1));
    assign take      = have_data && ((state == ST_IDLE) || (state == ST_STOP && bit_done));
    assign idle      = (state == ST_IDLE);

    always_comb begin
        case (state)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_q;
            default:   txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            shreg <= '0;
            cfg_q <= '0;
            par_q <= 1'b0;
            tcnt  <= '0;
            bcnt  <= '0;
        end else if (take) begin
            state <= ST_START;
            shreg <= next_byte;
            cfg_q <= cfg;
            par_q <= parity_bit(next_byte, cfg);
            tcnt  <= '0;
            bcnt  <= '0;
        end else if (tick && state != ST_IDLE) begin
            if (bit_done) begin
                tcnt <= '0;
                case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        shreg <= shreg >> 1;
                        bcnt  <= bcnt + 3'd1;
                        if (last_data) state <= cfg_q.par_en ? ST_PARITY : ST_STOP;
                    end
                    ST_PARITY: state <= ST_STOP;
                    default:   state <= ST_IDLE;
                endcase
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    // R5: the start bit is left only after a full bit time of ticks
    a_r5_start_len: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_START && state != ST_START) |-> ($past(tcnt) == LAST_1));

    // R9: the shifter becomes idle only out of the stop period
    a_r9_idle_from_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_IDLE) |-> ($past(state) == ST_STOP));

    // R3: a parity bit is only ever sent for a frame that asked for one
    a_r3_parity_enabled: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PARITY) |-> cfg_q.par_en);

    // R10: a stop period runs straight into a start only when a byte waited
    a_r10_chain_needs_data: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_STOP && state == ST_START) |-> $past(have_data));

endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq (
    input  logic clk,
    input  logic rst,
    input  logic thr_empty,
    input  logic ie,
    input  logic ack,
    output logic irq
);
    logic arm, arm_q, pend;

    assign arm = thr_empty & ie;
    assign irq = pend & arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            arm_q <= arm;
            if (arm && !arm_q) pend <= 1'b1;
            else if (ack)      pend <= 1'b0;
        end
    end

    // R11: pending is raised only by an enabled empty condition
    a_r11_set_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(thr_empty && ie));

    // R12: an acknowledge without a fresh empty event clears pending
    a_r12_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack && arm_q) |=> !pend);

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH    = 64,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       fifo_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [1:0] word_len,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       stop_two,
    input  logic       thr_ie,
    input  logic       iid_rd,
    output logic       txd,
    output logic       thr_empty,
    output logic       tsr_empty,
    output logic       irq
);
    frame_cfg_t cfg;
    logic [7:0] head;
    logic       q_empty, q_full, take;

    assign cfg = '{wlen: word_len, par_en: par_en, par_even: par_even, stop_two: stop_two};
    assign thr_empty = q_empty;

    uart_tx_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) i_queue (
        .clk(clk), .rst(rst), .fifo_mode(fifo_en),
        .push(wr_en), .din(wr_data), .pop(take),
        .dout(head), .empty(q_empty), .full(q_full)
    );

    uart_tx_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT)) i_shift (
        .clk(clk), .rst(rst), .tick(tick), .cfg(cfg),
        .have_data(!q_empty), .next_byte(head),
        .take(take), .txd(txd), .idle(tsr_empty)
    );

    uart_tx_irq i_irq (
        .clk(clk), .rst(rst), .thr_empty(q_empty), .ie(thr_ie),
        .ack(iid_rd), .irq(irq)
    );

    // R8: an empty queue stays empty until a write arrives
    a_r8_empty_holds: assert property (@(posedge clk) disable iff (rst)
        (thr_empty && !wr_en) |=> thr_empty);

    // R8: the queue only empties by handing a byte to the shifter
    a_r8_empty_by_take: assert property (@(posedge clk) disable iff (rst)
        $rose(thr_empty) |-> $past(take));

    // R9: a shifter taking data is busy on the next cycle
    a_r9_busy_after_take: assert property (@(posedge clk) disable iff (rst)
        take |=> !tsr_empty);

endmodule

// File: tb/test_uart_tx_core.sv
module test_uart_tx_core;

    logic       clk = 1'b0;
    logic       rst, tick, fifo_en, wr_en, par_en, par_even, stop_two, thr_ie, iid_rd;
    logic [7:0] wr_data;
    logic [1:0] word_len;
    logic       txd, thr_empty, tsr_empty, irq;

    always #2 clk = ~clk;

    uart_tx_core i_uart_tx_core (
        .clk(clk), .rst(rst), .tick(tick), .fifo_en(fifo_en), .wr_en(wr_en),
        .wr_data(wr_data), .word_len(word_len), .par_en(par_en), .par_even(par_even),
        .stop_two(stop_two), .thr_ie(thr_ie), .iid_rd(iid_rd),
        .txd(txd), .thr_empty(thr_empty), .tsr_empty(tsr_empty), .irq(irq)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // {data[7:0], word_len[1:0], par_en, par_even, stop_two}
    localparam logic [12:0] VEC [6] = '{
        {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0},
        {8'h3C, 2'd3, 1'b1, 1'b1, 1'b0},
        {8'h3D, 2'd3, 1'b1, 1'b0, 1'b1},
        {8'h15, 2'd0, 1'b0, 1'b0, 1'b1},
        {8'h1B, 2'd1, 1'b1, 1'b0, 1'b0},
        {8'hFF, 2'd2, 1'b1, 1'b1, 1'b1}
    };

    // frame monitor: decodes characters at bit centres
    bit         mon_en = 1'b1;
    int         mon_cnt = 0;
    logic [7:0] mon_data  [128];
    logic       mon_par   [128];
    logic       mon_ok    [128];
    int         mon_start [128];

    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && rst === 1'b0 && txd === 1'b0) begin
                int st;
                logic [7:0] d;
                logic p, ok;
                st = cyc;
                d = 8'h00;
                p = 1'b0;
                repeat (8) @(negedge clk);
                ok = (txd === 1'b0);
                for (int b = 0; b < 5 + int'(word_len); b++) begin
                    repeat (16) @(negedge clk);
                    d[b] = txd;
                end
                if (par_en) begin
                    repeat (16) @(negedge clk);
                    p = txd;
                end
                repeat (16) @(negedge clk);
                ok = ok && (txd === 1'b1);
                if (stop_two && word_len != 2'd0) begin
                    repeat (16) @(negedge clk);
                    ok = ok && (txd === 1'b1);
                end
                if (mon_cnt < 128) begin
                    mon_data[mon_cnt]  = d;
                    mon_par[mon_cnt]   = p;
                    mon_ok[mon_cnt]    = ok;
                    mon_start[mon_cnt] = st;
                    mon_cnt++;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (!(tsr_empty && thr_empty)) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    function automatic int frame_len(input logic [1:0] wl, input logic pe, input logic st2);
        int stop_t;
        stop_t = !st2 ? 16 : (wl == 2'd0 ? 24 : 32);
        return 16 * (1 + 5 + int'(wl) + int'(pe)) + stop_t;
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input logic [1:0] wl, input logic even);
        logic x;
        x = ^(d & (8'hFF >> (3 - int'(wl))));
        return even ? x : ~x;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base, t;
        logic [7:0] d;
        logic [1:0] wl;
        rst = 1'b1; tick = 1'b1; fifo_en = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
        word_len = 2'd3; par_en = 1'b0; par_even = 1'b0; stop_two = 1'b0;
        thr_ie = 1'b0; iid_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 txd", 32'(txd), 1);
        chk("R1 thr_empty", 32'(thr_empty), 1);
        chk("R1 tsr_empty", 32'(tsr_empty), 1);
        chk("R1 irq", 32'(irq), 0);
        repeat (4) @(negedge clk);

        // table of single-frame vectors: R2, R3, R4, R5
        foreach (VEC[i]) begin
            d = VEC[i][12:5];
            wl = VEC[i][4:3];
            word_len = wl; par_en = VEC[i][2]; par_even = VEC[i][1]; stop_two = VEC[i][0];
            @(negedge clk);
            base = mon_cnt;
            write_byte(d);
            while (tsr_empty) @(negedge clk);
            t = 0;
            while (!tsr_empty) begin t++; @(negedge clk); end
            wait_idle();
            chk("R5 frame length", 32'(t), 32'(frame_len(wl, VEC[i][2], VEC[i][0])));
            chk("R2 data bits", 32'(mon_data[base]), 32'(d & (8'hFF >> (3 - int'(wl)))));
            chk("R4 start/stop levels", 32'(mon_ok[base]), 1);
            if (VEC[i][2])
                chk("R3 parity", 32'(mon_par[base]), 32'(exp_par(d, wl, VEC[i][1])));
            chk("R2 one frame", 32'(mon_cnt - base), 1);
        end

        // non-FIFO holding register: R7, R8, R9
        word_len = 2'd3; par_en = 1'b0; stop_two = 1'b0; fifo_en = 1'b0;
        @(negedge clk);
        base = mon_cnt;
        write_byte(8'h5A);
        chk("R8 thr_empty low after write", 32'(thr_empty), 0);
        chk("R9 tsr_empty before load", 32'(tsr_empty), 1);
        @(negedge clk);
        chk("R8 thr_empty set on transfer", 32'(thr_empty), 1);
        chk("R9 tsr_empty low in frame", 32'(tsr_empty), 0);
        chk("R2 start bit out", 32'(txd), 0);
        write_byte(8'hC3);
        write_byte(8'h99);
        chk("R7 holding full", 32'(thr_empty), 0);
        wait_idle();
        chk("R7 frames sent", 32'(mon_cnt - base), 2);
        chk("R7 first byte", 32'(mon_data[base]), 32'h5A);
        chk("R7 second byte, third dropped", 32'(mon_data[base + 1]), 32'hC3);

        // FIFO mode burst of 66 writes: R6, R10
        fifo_en = 1'b1;
        @(negedge clk);
        base = mon_cnt;
        for (int i = 0; i < 66; i++) begin
            wr_en = 1'b1;
            wr_data = 8'(i);
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk("R8 queue not empty", 32'(thr_empty), 0);
        wait_idle();
        chk("R6 frames sent (last write dropped)", 32'(mon_cnt - base), 65);
        begin
            int bad_d, bad_s;
            bad_d = 0; bad_s = 0;
            for (int k = 0; k < 65; k++) begin
                if (mon_data[base + k] !== 8'(k)) bad_d++;
                if (k > 0 && mon_start[base + k] - mon_start[base + k - 1] != 160) bad_s++;
            end
            chk("R6 order", 32'(bad_d), 0);
            chk("R10 back-to-back spacing", 32'(bad_s), 0);
        end

        // interrupt: R11, R12
        @(negedge clk);
        chk("R11 no irq when disabled", 32'(irq), 0);
        thr_ie = 1'b1;
        @(negedge clk);
        chk("R11 irq on enable while empty", 32'(irq), 1);
        iid_rd = 1'b1;
        @(negedge clk);
        iid_rd = 1'b0;
        chk("R12 irq cleared by read", 32'(irq), 0);
        repeat (5) @(negedge clk);
        chk("R12 stays cleared", 32'(irq), 0);
        write_byte(8'h81);
        chk("R11 no irq while queued", 32'(irq), 0);
        @(negedge clk);
        chk("R11 not yet pending", 32'(irq), 0);
        @(negedge clk);
        chk("R11 irq on new empty event", 32'(irq), 1);
        thr_ie = 1'b0;
        @(negedge clk);
        chk("R11 masked by enable", 32'(irq), 0);
        wait_idle();

        // tick stall: R5
        mon_en = 1'b0;
        word_len = 2'd3; par_en = 1'b0; stop_two = 1'b0;
        @(negedge clk);
        write_byte(8'h00);
        while (tsr_empty) @(negedge clk);
        t = 0;
        repeat (30) begin t++; @(negedge clk); end
        tick = 1'b0;
        d[0] = txd;
        repeat (40) begin t++; @(negedge clk); end
        chk("R5 txd frozen without tick", 32'(txd), 32'(d[0]));
        tick = 1'b1;
        while (!tsr_empty) begin t++; @(negedge clk); end
        chk("R5 stalled frame length", 32'(t), 200);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule